// File: doc/BRIEF.md
# Load Issue Disambiguation Queue

This block is a small queue of in-flight memory operations placed right after address generation. Operations enter in program order. Each one carries its kind (load or store), a flag that says whether its address is known yet, and its address. When the address unit finishes, it writes the address into the waiting slot. Every cycle the block chooses which operations may go on toward the data cache, and it sends up to `NPORT` of them in any mix of loads and stores.

Loads are reordered without speculation. A load may overtake older loads at any time. A load may overtake an older store that is still waiting only when that store's address is already known and differs from the load's address in the low `CMP_BITS` bits. The upper address bits are not compared. A store whose address is still unknown holds back every younger load. A low-bit match holds the load in place and raises a per-slot flag marking it as a candidate for store-to-load forwarding. Stores always leave in program order among themselves.

Slots are held on a ring of head and tail pointers. A slot that has issued stays occupied until every older slot has also issued. The head pointer then moves past the whole run of issued slots in a single cycle.

Top module: `ldq_disamb`

## Requirements
- R1: An accepted allocation (`alloc_valid` high while `alloc_ready` is high) writes the slot that `alloc_idx` shows. That slot is the tail, which steps by one modulo `DEPTH` after each accepted allocation. `alloc_is_store` = 1 marks a store and 0 marks a load.
- R2: `alloc_ready` is low while all `DEPTH` slots are occupied. An `alloc_valid` that arrives while `alloc_ready` is low is ignored and does not move the tail.
- R3: An address written through `agu_valid`/`agu_idx`/`agu_addr` is captured in its slot. The slot becomes eligible to issue from the following cycle, and `iss_addr` carries exactly that address.
- R4: A load whose address is known may issue ahead of any number of older loads that have not issued.
- R5: A load never issues while an older store that has not issued still has an unknown address.
- R6: A load never issues while an older store that has not issued has a known address equal to it in bits `[CMP_BITS-1:0]`. Higher bits take no part in the compare. While such a match holds, `fwd_cand[slot]` is 1 for that load. It is 0 for every other slot.
- R7: A load whose address is known, and whose older unissued stores all have known addresses differing from it in the low bits, may issue ahead of those stores.
- R8: A store issues only when its own address is known and every older store has already issued.
- R9: At most `NPORT` operations issue per cycle. The eligible operations are taken oldest first. Port 0 carries the oldest, and the ports are filled from 0 upward with no gaps.
- R10: An operation issues exactly once. Issued slots at the head are freed one cycle after the youngest of them issues, so a queue that has fully drained shows `alloc_ready` high again.
- R11: After reset the queue is empty: `alloc_ready` = 1, `alloc_idx` = 0, no `iss_vld` bit is set and `fwd_cand` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to enter a new operation |
| alloc_is_store | input | 1 | Kind of the new operation: 1 store, 0 load |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | $clog2(DEPTH) | Slot the next accepted operation takes |
| agu_valid | input | 1 | Address-generation result is present |
| agu_idx | input | $clog2(DEPTH) | Slot the result belongs to |
| agu_addr | input | ADDR_W | Generated address |
| iss_vld | output | NPORT | Per issue port: an operation leaves this cycle |
| iss_idx | output | NPORT x $clog2(DEPTH) | Slot issued on each port |
| iss_is_store | output | NPORT | Kind of the issued operation |
| iss_addr | output | NPORT x ADDR_W | Address of the issued operation |
| fwd_cand | output | DEPTH | Per slot: load held back by a low-bit match with an older store |

## Verification
The hardest case to reach from the ports is a load held back by an older store while a further, unrelated operation stands ready behind it. The stimulus that reaches it has two parts. First, every order of up to four loads and stores is allocated before any address is written. Then the addresses are released known-subset first, sweeping all sixteen subsets, so that a store with an unknown address can sit between ready loads. Three address patterns are used with each order. One keeps all low bits distinct. One makes every low field equal while the high bits differ. One pairs neighbouring operations. A one-load filler ahead of each case moves the head so that the age order wraps around the ring.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  typedef enum logic {
    OPK_LOAD  = 1'b0,
    OPK_STORE = 1'b1
  } op_kind_e;

  // position of a slot counted from the head (0 = oldest)
  function automatic int unsigned age_of(int unsigned slot, int unsigned head,
                                         int unsigned depth);
    return (slot + depth - head) % depth;
  endfunction

  // ring step
  function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                           int unsigned depth);
    return (base + step) % depth;
  endfunction

  // partial address compare on the low bits only
  function automatic logic low_match(logic [63:0] a, logic [63:0] b, int unsigned nbits);
    logic [63:0] m;
    m = (nbits >= 64) ? '1 : ((64'd1 << nbits) - 64'd1);
    return ((a & m) == (b & m));
  endfunction

endpackage

// File: rtl/ldq_ptrs.sv
module ldq_ptrs #(
  parameter int DEPTH = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_fire,
  input  logic [DEPTH-1:0]           ent_valid,
  input  logic [DEPTH-1:0]           ent_done,
  output logic [$clog2(DEPTH)-1:0]   head,
  output logic [$clog2(DEPTH)-1:0]   tail,
  output logic [$clog2(DEPTH+1)-1:0] occ_cnt,
  output logic [DEPTH-1:0]           free_mask
);
  import ldq_pkg::*;

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] free_n;

  // leading run of issued slots starting at head
  always_comb begin
    logic stop;
    int unsigned p;
    free_mask = '0;
    free_n    = '0;
    stop      = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      p = ring_add(int'(head), k, DEPTH);
      if (!stop && ent_valid[p] && ent_done[p]) begin
        free_mask[p] = 1'b1;
        free_n       = free_n + CW'(1);
      end else begin
        stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      occ_cnt <= '0;
    end else begin
      head    <= IW'(ring_add(int'(head), int'(free_n), DEPTH));
      if (alloc_fire) tail <= IW'(ring_add(int'(tail), 1, DEPTH));
      occ_cnt <= occ_cnt + CW'(alloc_fire) - free_n;
    end
  end

endmodule

// File: rtl/ldq_slots.sv
module ldq_slots #(
  parameter int DEPTH  = 12,
  parameter int ADDR_W = 32,
  parameter int NPORT  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  alloc_fire,
  input  logic [$clog2(DEPTH)-1:0]              tail,
  input  logic                                  alloc_is_store,
  input  logic                                  agu_valid,
  input  logic [$clog2(DEPTH)-1:0]              agu_idx,
  input  logic [ADDR_W-1:0]                     agu_addr,
  input  logic [NPORT-1:0]                      iss_vld,
  input  logic [NPORT-1:0][$clog2(DEPTH)-1:0]   iss_idx,
  input  logic [DEPTH-1:0]                      free_mask,
  output logic [DEPTH-1:0]                      ent_valid,
  output logic [DEPTH-1:0]                      ent_st,
  output logic [DEPTH-1:0]                      ent_aval,
  output logic [DEPTH-1:0]                      ent_done,
  output logic [DEPTH-1:0][ADDR_W-1:0]          ent_addr
);
  import ldq_pkg::*;

  localparam int IW = $clog2(DEPTH);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take_alloc;
    logic take_addr;
    logic take_issue;

    assign take_alloc = alloc_fire && (tail == IW'(i));
    assign take_addr  = agu_valid && (agu_idx == IW'(i)) && ent_valid[i];

    always_comb begin
      take_issue = 1'b0;
      for (int p = 0; p < NPORT; p++)
        if (iss_vld[p] && (iss_idx[p] == IW'(i))) take_issue = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_st[i]    <= 1'b0;
        ent_aval[i]  <= 1'b0;
        ent_done[i]  <= 1'b0;
        ent_addr[i]  <= '0;
      end else if (take_alloc) begin
        ent_valid[i] <= 1'b1;
        ent_st[i]    <= (alloc_is_store == OPK_STORE);
        ent_aval[i]  <= 1'b0;
        ent_done[i]  <= 1'b0;
      end else if (free_mask[i]) begin
        ent_valid[i] <= 1'b0;
        ent_aval[i]  <= 1'b0;
        ent_done[i]  <= 1'b0;
      end else begin
        if (take_addr) begin
          ent_aval[i] <= 1'b1;
          ent_addr[i] <= agu_addr;
        end
        if (take_issue) ent_done[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ldq_hazard.sv
module ldq_hazard #(
  parameter int DEPTH    = 12,
  parameter int ADDR_W   = 32,
  parameter int CMP_BITS = 12
) (
  input  logic [$clog2(DEPTH)-1:0]     head,
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0]             ent_st,
  input  logic [DEPTH-1:0]             ent_aval,
  input  logic [DEPTH-1:0]             ent_done,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  output logic [DEPTH-1:0]             ready,
  output logic [DEPTH-1:0]             blk_unknown,
  output logic [DEPTH-1:0]             blk_match,
  output logic [DEPTH-1:0]             fwd_cand
);
  import ldq_pkg::*;

  localparam int CB = (CMP_BITS < ADDR_W) ? CMP_BITS : ADDR_W;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic older_st;
    logic unk;
    logic hit;
    logic live;

    assign live = ent_valid[i] && !ent_done[i];

    always_comb begin
      older_st = 1'b0;
      unk      = 1'b0;
      hit      = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (age_of(j, int'(head), DEPTH) < age_of(i, int'(head), DEPTH) &&
            ent_valid[j] && ent_st[j] && !ent_done[j]) begin
          older_st = 1'b1;
          if (!ent_aval[j]) unk = 1'b1;
          else if (low_match(64'(ent_addr[j]), 64'(ent_addr[i]), CB)) hit = 1'b1;
        end
      end
    end

    assign blk_unknown[i] = live && !ent_st[i] && unk;
    assign blk_match[i]   = live && !ent_st[i] && ent_aval[i] && hit;
    assign fwd_cand[i]    = blk_match[i];
    assign ready[i]       = live && ent_aval[i] &&
                            (ent_st[i] ? !older_st : (!unk && !hit));
  end

endmodule

// File: rtl/ldq_pick.sv
module ldq_pick #(
  parameter int DEPTH = 12,
  parameter int NPORT = 2
) (
  input  logic [$clog2(DEPTH)-1:0]            head,
  input  logic [DEPTH-1:0]                    ready,
  output logic [NPORT-1:0]                    sel_vld,
  output logic [NPORT-1:0][$clog2(DEPTH)-1:0] sel_idx
);
  import ldq_pkg::*;

  localparam int IW = $clog2(DEPTH);

  always_comb begin
    int n;
    int unsigned p;
    sel_vld = '0;
    sel_idx = '0;
    n       = 0;
    for (int k = 0; k < DEPTH; k++) begin
      p = ring_add(int'(head), k, DEPTH);
      if (ready[p] && n < NPORT) begin
        sel_vld[n] = 1'b1;
        sel_idx[n] = IW'(p);
        n++;
      end
    end
  end

endmodule

// File: rtl/ldq_disamb.sv
module ldq_disamb #(
  parameter int DEPTH    = 12,
  parameter int ADDR_W   = 32,
  parameter int CMP_BITS = 12,
  parameter int NPORT    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 alloc_valid,
  input  logic                                 alloc_is_store,
  output logic                                 alloc_ready,
  output logic [$clog2(DEPTH)-1:0]             alloc_idx,
  input  logic                                 agu_valid,
  input  logic [$clog2(DEPTH)-1:0]             agu_idx,
  input  logic [ADDR_W-1:0]                    agu_addr,
  output logic [NPORT-1:0]                     iss_vld,
  output logic [NPORT-1:0][$clog2(DEPTH)-1:0]  iss_idx,
  output logic [NPORT-1:0]                     iss_is_store,
  output logic [NPORT-1:0][ADDR_W-1:0]         iss_addr,
  output logic [DEPTH-1:0]                     fwd_cand
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  // named internal events, observed by the bound checker
  logic [IW-1:0]              head;
  logic [IW-1:0]              tail;
  logic [CW-1:0]              occ_cnt;
  logic [DEPTH-1:0]           free_mask;
  logic                       alloc_fire;
  logic [DEPTH-1:0]           ent_valid;
  logic [DEPTH-1:0]           ent_st;
  logic [DEPTH-1:0]           ent_aval;
  logic [DEPTH-1:0]           ent_done;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0]           ready;
  logic [DEPTH-1:0]           blk_unknown;
  logic [DEPTH-1:0]           blk_match;

  assign alloc_ready = (occ_cnt != CW'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;

  ldq_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_fire(alloc_fire),
    .ent_valid (ent_valid),
    .ent_done  (ent_done),
    .head      (head),
    .tail      (tail),
    .occ_cnt   (occ_cnt),
    .free_mask (free_mask)
  );

  ldq_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NPORT(NPORT)) slots_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_fire    (alloc_fire),
    .tail          (tail),
    .alloc_is_store(alloc_is_store),
    .agu_valid     (agu_valid),
    .agu_idx       (agu_idx),
    .agu_addr      (agu_addr),
    .iss_vld       (iss_vld),
    .iss_idx       (iss_idx),
    .free_mask     (free_mask),
    .ent_valid     (ent_valid),
    .ent_st        (ent_st),
    .ent_aval      (ent_aval),
    .ent_done      (ent_done),
    .ent_addr      (ent_addr)
  );

  ldq_hazard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CMP_BITS(CMP_BITS)) haz_i (
    .head       (head),
    .ent_valid  (ent_valid),
    .ent_st     (ent_st),
    .ent_aval   (ent_aval),
    .ent_done   (ent_done),
    .ent_addr   (ent_addr),
    .ready      (ready),
    .blk_unknown(blk_unknown),
    .blk_match  (blk_match),
    .fwd_cand   (fwd_cand)
  );

  ldq_pick #(.DEPTH(DEPTH), .NPORT(NPORT)) pick_i (
    .head   (head),
    .ready  (ready),
    .sel_vld(iss_vld),
    .sel_idx(iss_idx)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign iss_is_store[p] = ent_st[iss_idx[p]];
    assign iss_addr[p]     = ent_addr[iss_idx[p]];
  end

endmodule

// File: rtl/ldq_disamb_chk.sv
module ldq_disamb_chk #(
  parameter int DEPTH = 12,
  parameter int NPORT = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                alloc_valid,
  input logic                                alloc_ready,
  input logic [NPORT-1:0]                    iss_vld,
  input logic [NPORT-1:0][$clog2(DEPTH)-1:0] iss_idx,
  input logic [DEPTH-1:0]                    ent_valid,
  input logic [DEPTH-1:0]                    ent_aval,
  input logic [DEPTH-1:0]                    ent_done,
  input logic [DEPTH-1:0]                    blk_unknown,
  input logic [DEPTH-1:0]                    blk_match,
  input logic [$clog2(DEPTH+1)-1:0]          occ_cnt
);
  localparam int CW = $clog2(DEPTH+1);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_cnt == CW'(DEPTH)) |-> !alloc_ready);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= CW'(DEPTH));

  p_alloc_counts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (occ_cnt != '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    p_issue_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[p] |-> (ent_valid[iss_idx[p]] && !ent_done[iss_idx[p]] && ent_aval[iss_idx[p]]));

    p_no_unknown_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[p] |-> !blk_unknown[iss_idx[p]]);

    p_no_match_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[p] |-> !blk_match[iss_idx[p]]);

    p_issue_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[p] |=> !ent_valid[$past(iss_idx[p])] || ent_done[$past(iss_idx[p])]);

    if (p > 0) begin : g_pair
      p_port_pack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[p] |-> iss_vld[p-1]);
      p_port_distinct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[p] |-> (iss_idx[p] != iss_idx[p-1]));
    end
  end

endmodule

bind ldq_disamb ldq_disamb_chk #(.DEPTH(DEPTH), .NPORT(NPORT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready),
  .iss_vld    (iss_vld),
  .iss_idx    (iss_idx),
  .ent_valid  (ent_valid),
  .ent_aval   (ent_aval),
  .ent_done   (ent_done),
  .blk_unknown(blk_unknown),
  .blk_match  (blk_match),
  .occ_cnt    (occ_cnt)
);

// File: tb/ldq_disamb_tb.sv
module ldq_disamb_tb_top;
  localparam int DEPTH = 4;
  localparam int ADDR_W = 6;
  localparam int CMP_BITS = 3;
  localparam int NPORT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic alloc_is_store = 1'b0;
  logic alloc_ready;
  logic [1:0] alloc_idx;
  logic agu_valid = 1'b0;
  logic [1:0] agu_idx = '0;
  logic [ADDR_W-1:0] agu_addr = '0;
  logic [NPORT-1:0] iss_vld;
  logic [NPORT-1:0][1:0] iss_idx;
  logic [NPORT-1:0] iss_is_store;
  logic [NPORT-1:0][ADDR_W-1:0] iss_addr;
  logic [DEPTH-1:0] fwd_cand;

  always #2.5 clk = ~clk;

  ldq_disamb #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CMP_BITS(CMP_BITS), .NPORT(NPORT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .agu_valid(agu_valid), .agu_idx(agu_idx), .agu_addr(agu_addr),
    .iss_vld(iss_vld), .iss_idx(iss_idx), .iss_is_store(iss_is_store),
    .iss_addr(iss_addr), .fwd_cand(fwd_cand)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench-side model of the current group, in program order
  int n_ops;
  int base;
  int btail = 0;
  bit m_st[4];
  bit m_aval[4];
  bit m_done[4];
  logic [ADDR_W-1:0] m_addr[4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_cycle();
    bit rdy[4];
    bit fw[4];
    int pk[2];
    int np;
    int nrdy;
    bit any_unk;
    bit any_mt;
    bit st_pick;
    bit past_st;
    string tag;
    np = 0; nrdy = 0; any_unk = 0; any_mt = 0; st_pick = 0; past_st = 0;
    pk[0] = 0; pk[1] = 0;
    for (int k = 0; k < 4; k++) begin
      rdy[k] = 0; fw[k] = 0;
    end
    for (int k = 0; k < n_ops; k++) begin
      bit ost, unk, mt;
      ost = 0; unk = 0; mt = 0;
      if (!m_done[k]) begin
        for (int j = 0; j < k; j++) begin
          if (m_st[j] && !m_done[j]) begin
            ost = 1;
            if (!m_aval[j]) unk = 1;
            else if (m_addr[j][CMP_BITS-1:0] == m_addr[k][CMP_BITS-1:0]) mt = 1;
          end
        end
        if (m_st[k]) rdy[k] = m_aval[k] && !ost;
        else begin
          rdy[k] = m_aval[k] && !unk && !mt;
          fw[k]  = m_aval[k] && mt;
          if (m_aval[k] && unk) any_unk = 1;
          if (m_aval[k] && mt) any_mt = 1;
        end
        if (rdy[k]) begin
          nrdy++;
          if (np < 2) begin
            pk[np] = k; np++;
            if (m_st[k]) st_pick = 1;
            if (!m_st[k] && ost) past_st = 1;
          end
        end
      end
    end
    if (any_unk) tag = "R5";
    else if (any_mt) tag = "R6";
    else if (nrdy > NPORT) tag = "R9";
    else if (st_pick) tag = "R8";
    else if (past_st) tag = "R7";
    else tag = "R4";
    for (int p = 0; p < NPORT; p++) begin
      bit ev;
      int slot;
      ev = (p < np);
      chk(iss_vld[p] === ev, tag, $sformatf("iss_vld[%0d]", p), int'(iss_vld[p]), int'(ev));
      if (ev) begin
        slot = (base + pk[p]) % DEPTH;
        chk(iss_idx[p] === 2'(slot), tag, $sformatf("iss_idx[%0d]", p), int'(iss_idx[p]), slot);
        chk(iss_is_store[p] === m_st[pk[p]], "R8", $sformatf("iss_is_store[%0d]", p),
            int'(iss_is_store[p]), int'(m_st[pk[p]]));
        chk(iss_addr[p] === m_addr[pk[p]], "R3", $sformatf("iss_addr[%0d]", p),
            int'(iss_addr[p]), int'(m_addr[pk[p]]));
      end
    end
    for (int s = 0; s < DEPTH; s++) begin
      bit ef;
      ef = 0;
      for (int k = 0; k < n_ops; k++)
        if ((base + k) % DEPTH == s) ef = fw[k];
      chk(fwd_cand[s] === ef, "R6", $sformatf("fwd_cand[%0d]", s), int'(fwd_cand[s]), int'(ef));
    end
    for (int q = 0; q < np; q++) m_done[pk[q]] = 1;
  endtask

  task automatic tick();
    @(negedge clk);
    if (!finished) check_cycle();
  endtask

  function automatic bit all_done();
    for (int k = 0; k < n_ops; k++) if (!m_done[k]) return 0;
    return 1;
  endfunction

  // one group: n operations with kinds ty, known-first mask km, address pattern pt
  task automatic run_group(input int n, input logic [3:0] ty, input logic [3:0] km,
                           input int pt);
    int guard;
    base = btail;
    n_ops = n;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] lo;
      m_st[k] = ty[k]; m_aval[k] = 0; m_done[k] = 0;
      lo = (pt == 0) ? 3'(k) : (pt == 1) ? 3'd5 : 3'(k >> 1);
      m_addr[k] = {3'(k + 1), lo};
    end
    for (int k = 0; k < n; k++) begin
      tick();
      chk(alloc_ready === 1'b1, "R1", "alloc_ready before alloc", int'(alloc_ready), 1);
      chk(alloc_idx === 2'((base + k) % DEPTH), "R1", "alloc_idx", int'(alloc_idx),
          (base + k) % DEPTH);
      alloc_valid = 1'b1; alloc_is_store = ty[k];
    end
    tick();
    if (n == DEPTH) begin
      chk(alloc_ready === 1'b0, "R2", "alloc_ready when full", int'(alloc_ready), 0);
      alloc_valid = 1'b1; alloc_is_store = 1'b1;
      tick();
    end
    alloc_valid = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < n; k++) begin
        if (km[k] == (pass == 0)) begin
          tick();
          agu_valid = 1'b1; agu_idx = 2'((base + k) % DEPTH); agu_addr = m_addr[k];
          m_aval[k] = 1;
        end
      end
    end
    tick();
    agu_valid = 1'b0;
    guard = 0;
    while (!all_done() && guard < 20) begin
      tick(); guard++;
    end
    chk(all_done(), "R10", "group drained", guard, 0);
    tick();
    tick();
    chk(alloc_ready === 1'b1, "R10", "alloc_ready after drain", int'(alloc_ready), 1);
    btail = (base + n) % DEPTH;
  endtask

  initial begin
    n_ops = 0; base = 0;
    for (int k = 0; k < 4; k++) begin
      m_st[k] = 0; m_aval[k] = 0; m_done[k] = 0; m_addr[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(alloc_ready === 1'b1, "R11", "reset alloc_ready", int'(alloc_ready), 1);
    chk(alloc_idx === 2'd0, "R11", "reset alloc_idx", int'(alloc_idx), 0);
    chk(iss_vld === '0, "R11", "reset iss_vld", int'(iss_vld), 0);
    chk(fwd_cand === '0, "R11", "reset fwd_cand", int'(fwd_cand), 0);
    for (int pt = 0; pt < 3; pt++)
      for (int ty = 0; ty < 16; ty++)
        for (int km = 0; km < 16; km++) begin
          run_group(1, 4'b0000, 4'b0001, 0);
          run_group(4, 4'(ty), 4'(km), pt);
        end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule